// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block supplies the frame timing for a multi-slot time-division-multiplexed serial audio port. A bit-clock strobe (`bclk_en`, one system clock wide per serial bit) advances a frame position counter. The frame is `frame_div + 1` bits long. From that position the block derives a bit-within-slot index and a slot index for the serializers next to it, a start-of-frame marker, and, when the port is the timing master, a frame sync. The frame sync can be a one-bit pulse placed on the first bit of the frame ("late") or on the last bit of the previous frame ("early"). It can also be a wide pulse that covers the whole of slot 0.

When the port follows an external timing source, the block does not drive the sync. It samples the incoming sync on each bit strobe and realigns its counters to the rising edge. A combinational check, registered once, flags configurations whose frame is too short for the slots it has to carry. While that flag is set, all frame activity is held off.

Top module: `tdm_fsync_gen`

## Requirements
- R1: While running (`glb_en`=1, `cfg_err`=0), each `bclk_en` strobe advances the frame position by one, and the position wraps to 0 after position `frame_div`. A frame is therefore `frame_div + 1` strobes long.
- R2: `bit_idx` equals the frame position modulo `slot_len`, and `slot_idx` equals the frame position divided by `slot_len`.
- R3: In master mode (`slave_mode`=0) with short sync (`long_sync`=0) and late placement (`early_pos`=0), `fsync` is high exactly while the position is 0.
- R4: In master mode with short sync and early placement (`early_pos`=1), `fsync` is high exactly while the position equals `frame_div`. No pulse precedes the first frame after enable.
- R5: In master mode with long sync (`long_sync`=1), `fsync` is high while the position is below `slot_len`, and `early_pos` has no effect.
- R6: `cfg_err` is 1 when `frame_div + 1 < slot_len * max(tx_slots, rx_slots)` or when `slot_len` is 0. While it is 1, `fsync` and `sof` are low and both indices read 0.
- R7: With long sync, `cfg_err` is also 1 when either `tx_slots` or `rx_slots` is 1 or less and `frame_div + 1 <= slot_len`. The same settings with short sync raise no error.
- R8: With `glb_en`=0, both indices are 0 one clock later and `fsync` and `sof` are low. After enable, counting restarts at position 0.
- R9: In slave mode (`slave_mode`=1), `fsync` stays low. A `sync_in` value of 1 sampled at a strobe, when the previous sampled value was 0, sets the next position to 0 in short-early mode and to 1 otherwise. A `sync_in` held high does not realign again.
- R10: `cfg_err` reflects the configuration inputs one clock after they change, whether or not `glb_en` is set.
- R11: While running, `sof` is high exactly while the position is 0, in both master and slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_en | input | 1 | Bit-clock strobe, one clock wide per serial bit |
| glb_en | input | 1 | Global enable for all frame activity |
| slave_mode | input | 1 | 0 = drive sync, 1 = follow `sync_in` |
| long_sync | input | 1 | 0 = one-bit sync, 1 = slot-wide sync |
| early_pos | input | 1 | Short sync only: 0 = late, 1 = early |
| frame_div | input | DIV_W | Frame length minus one, in bits |
| slot_len | input | SLEN_W | Bits per slot |
| tx_slots | input | SCNT_W | Slot count of the transmit direction |
| rx_slots | input | SCNT_W | Slot count of the receive direction |
| sync_in | input | 1 | External frame sync, sampled at strobes |
| fsync | output | 1 | Generated frame sync |
| sof | output | 1 | High during frame position 0 |
| bit_idx | output | SLEN_W | Bit index inside the current slot |
| slot_idx | output | DIV_W | Slot index inside the frame |
| cfg_err | output | 1 | Configuration check failed |

## Verification
The bench builds the block with `DIV_W`=8, `SLEN_W`=6 and `SCNT_W`=4. With these values the largest divider, 255, is reached with 32-bit slots and 8 slots, so a wrap at the very top of the position counter is exercised in a few hundred strobes. The narrow divider also makes frames too short for their slots easy to produce, both under the product rule and under the long-sync rule. Frames that are not a multiple of the slot length, and slave realignment in both placements, are run at the same widths.

// File: rtl/tdm_fsync_pkg.sv
package tdm_fsync_pkg;

  typedef enum logic [1:0] {
    SHAPE_PULSE_LATE  = 2'd0,
    SHAPE_PULSE_EARLY = 2'd1,
    SHAPE_SLOT_WIDE   = 2'd2
  } fs_shape_e;

  function automatic fs_shape_e shape_of(input logic long_sel, input logic early_sel);
    fs_shape_e s;
    if (long_sel)       s = SHAPE_SLOT_WIDE;
    else if (early_sel) s = SHAPE_PULSE_EARLY;
    else                s = SHAPE_PULSE_LATE;
    return s;
  endfunction

endpackage

// File: rtl/tdm_cfg_check.sv
module tdm_cfg_check #(
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6,
  parameter int SCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  frame_div,
  input  logic [SLEN_W-1:0] slot_len,
  input  logic [SCNT_W-1:0] tx_slots,
  input  logic [SCNT_W-1:0] rx_slots,
  input  logic              long_sync,
  output logic              cfg_err
);
  localparam int LEN_W  = DIV_W + 1;
  localparam int PROD_W = SLEN_W + SCNT_W;
  localparam int CMP_W  = (LEN_W > PROD_W) ? LEN_W : PROD_W;

  logic [SCNT_W-1:0] max_slots;
  logic [PROD_W-1:0] need_bits;
  logic [CMP_W-1:0]  frame_len;
  logic [CMP_W-1:0]  need_ext;
  logic [CMP_W-1:0]  slen_ext;
  logic              too_short;
  logic              long_bad;
  logic              zero_slot;
  logic              err_d;
  logic              err_q;

  always_comb begin
    max_slots = (tx_slots > rx_slots) ? tx_slots : rx_slots;
    need_bits = {{SCNT_W{1'b0}}, slot_len} * {{SLEN_W{1'b0}}, max_slots};
    frame_len = CMP_W'(frame_div) + CMP_W'(1);
    need_ext  = CMP_W'(need_bits);
    slen_ext  = CMP_W'(slot_len);
    too_short = frame_len < need_ext;
    zero_slot = (slot_len == '0);
    long_bad  = long_sync
              && ((tx_slots <= SCNT_W'(1)) || (rx_slots <= SCNT_W'(1)))
              && (frame_len <= slen_ext);
    err_d     = too_short | long_bad | zero_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign cfg_err = err_q;

endmodule

// File: rtl/tdm_slave_align.sv
module tdm_slave_align (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic adv,
  input  logic slave_mode,
  input  logic early_short,
  input  logic sync_in,
  output logic load,
  output logic load_zero
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = prev_q;
    if (!run)     prev_d = 1'b0;
    else if (adv) prev_d = sync_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign load      = run & slave_mode & adv & sync_in & ~prev_q;
  assign load_zero = early_short;

endmodule

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              adv,
  input  logic              load,
  input  logic              load_zero,
  input  logic [DIV_W-1:0]  frame_div,
  input  logic [SLEN_W-1:0] slot_len,
  output logic [DIV_W-1:0]  pos,
  output logic [SLEN_W-1:0] bit_idx,
  output logic [DIV_W-1:0]  slot_idx
);
  logic [DIV_W-1:0]  pos_q,  pos_d;
  logic [SLEN_W-1:0] bit_q,  bit_d;
  logic [DIV_W-1:0]  slot_q, slot_d;
  logic              slot_end;

  assign slot_end = (bit_q == slot_len - SLEN_W'(1));

  always_comb begin
    pos_d  = pos_q;
    bit_d  = bit_q;
    slot_d = slot_q;
    if (!run) begin
      pos_d  = '0;
      bit_d  = '0;
      slot_d = '0;
    end else if (adv) begin
      if (load) begin
        if (load_zero) begin
          pos_d  = '0;
          bit_d  = '0;
          slot_d = '0;
        end else begin
          pos_d = DIV_W'(1);
          if (slot_len == SLEN_W'(1)) begin
            bit_d  = '0;
            slot_d = DIV_W'(1);
          end else begin
            bit_d  = SLEN_W'(1);
            slot_d = '0;
          end
        end
      end else if (pos_q >= frame_div) begin
        pos_d  = '0;
        bit_d  = '0;
        slot_d = '0;
      end else begin
        pos_d = pos_q + DIV_W'(1);
        if (slot_end) begin
          bit_d  = '0;
          slot_d = slot_q + DIV_W'(1);
        end else begin
          bit_d  = bit_q + SLEN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      pos_q  <= pos_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end

  assign pos      = pos_q;
  assign bit_idx  = bit_q;
  assign slot_idx = slot_q;

endmodule

// File: rtl/tdm_sync_shaper.sv
module tdm_sync_shaper
  import tdm_fsync_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6
) (
  input  logic              drive,
  input  fs_shape_e         shape,
  input  logic [DIV_W-1:0]  pos,
  input  logic [DIV_W-1:0]  frame_div,
  input  logic [SLEN_W-1:0] slot_len,
  output logic              fsync
);
  localparam int PW = (DIV_W > SLEN_W) ? DIV_W : SLEN_W;

  logic raw;

  always_comb begin
    unique case (shape)
      SHAPE_PULSE_EARLY: raw = (pos == frame_div);
      SHAPE_SLOT_WIDE:   raw = (PW'(pos) < PW'(slot_len));
      default:           raw = (pos == '0);
    endcase
  end

  assign fsync = drive & raw;

endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
  import tdm_fsync_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6,
  parameter int SCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_en,
  input  logic              glb_en,
  input  logic              slave_mode,
  input  logic              long_sync,
  input  logic              early_pos,
  input  logic [DIV_W-1:0]  frame_div,
  input  logic [SLEN_W-1:0] slot_len,
  input  logic [SCNT_W-1:0] tx_slots,
  input  logic [SCNT_W-1:0] rx_slots,
  input  logic              sync_in,
  output logic              fsync,
  output logic              sof,
  output logic [SLEN_W-1:0] bit_idx,
  output logic [DIV_W-1:0]  slot_idx,
  output logic              cfg_err
);
  fs_shape_e        shape;
  logic             run;
  logic             err;
  logic             load;
  logic             load_zero;
  logic [DIV_W-1:0] pos;

  assign shape = shape_of(long_sync, early_pos);
  assign run   = glb_en & ~err;

  tdm_cfg_check #(.DIV_W(DIV_W), .SLEN_W(SLEN_W), .SCNT_W(SCNT_W)) u_check (
    .clk(clk), .rst_n(rst_n), .frame_div(frame_div), .slot_len(slot_len),
    .tx_slots(tx_slots), .rx_slots(rx_slots), .long_sync(long_sync),
    .cfg_err(err)
  );

  tdm_slave_align u_align (
    .clk(clk), .rst_n(rst_n), .run(run), .adv(bclk_en),
    .slave_mode(slave_mode), .early_short(shape == SHAPE_PULSE_EARLY),
    .sync_in(sync_in), .load(load), .load_zero(load_zero)
  );

  tdm_frame_counter #(.DIV_W(DIV_W), .SLEN_W(SLEN_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .adv(bclk_en), .load(load),
    .load_zero(load_zero), .frame_div(frame_div), .slot_len(slot_len),
    .pos(pos), .bit_idx(bit_idx), .slot_idx(slot_idx)
  );

  tdm_sync_shaper #(.DIV_W(DIV_W), .SLEN_W(SLEN_W)) u_shape (
    .drive(run & ~slave_mode), .shape(shape), .pos(pos),
    .frame_div(frame_div), .slot_len(slot_len), .fsync(fsync)
  );

  assign sof     = run & (pos == '0);
  assign cfg_err = err;

endmodule

// File: rtl/tdm_fsync_gen_chk.sv
module tdm_fsync_gen_chk #(
  parameter int DIV_W  = 10,
  parameter int SLEN_W = 6,
  parameter int SCNT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bclk_en,
  input logic              glb_en,
  input logic              slave_mode,
  input logic              long_sync,
  input logic              early_pos,
  input logic [DIV_W-1:0]  frame_div,
  input logic [SLEN_W-1:0] slot_len,
  input logic [SCNT_W-1:0] tx_slots,
  input logic [SCNT_W-1:0] rx_slots,
  input logic              sync_in,
  input logic              fsync,
  input logic              sof,
  input logic [SLEN_W-1:0] bit_idx,
  input logic [DIV_W-1:0]  slot_idx,
  input logic              cfg_err
);

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!fsync && !sof));

  p_slave_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> !fsync);

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (bit_idx == '0 && slot_idx == '0));

  p_sof_at_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (bit_idx == '0 && slot_idx == '0));

  p_short_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && !long_sync && bclk_en && frame_div != '0) |=>
      (!fsync || long_sync || !$stable(early_pos) || !$stable(frame_div)
       || !$stable(glb_en)));

endmodule

bind tdm_fsync_gen tdm_fsync_gen_chk #(
  .DIV_W(DIV_W), .SLEN_W(SLEN_W), .SCNT_W(SCNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .glb_en(glb_en),
  .slave_mode(slave_mode), .long_sync(long_sync), .early_pos(early_pos),
  .frame_div(frame_div), .slot_len(slot_len), .tx_slots(tx_slots),
  .rx_slots(rx_slots), .sync_in(sync_in), .fsync(fsync), .sof(sof),
  .bit_idx(bit_idx), .slot_idx(slot_idx), .cfg_err(cfg_err)
);

// File: tb/tdm_fsync_gen_tb.sv
module tdm_fsync_gen_tb_top;
  localparam int DIV_W  = 8;
  localparam int SLEN_W = 6;
  localparam int SCNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_en = 1'b0, glb_en = 1'b0, slave_mode = 1'b0;
  logic long_sync = 1'b0, early_pos = 1'b0, sync_in = 1'b0;
  logic [DIV_W-1:0]  frame_div = '0;
  logic [SLEN_W-1:0] slot_len = '0;
  logic [SCNT_W-1:0] tx_slots = '0, rx_slots = '0;
  logic fsync, sof, cfg_err;
  logic [SLEN_W-1:0] bit_idx;
  logic [DIV_W-1:0]  slot_idx;

  always #2 clk = ~clk;

  tdm_fsync_gen #(.DIV_W(DIV_W), .SLEN_W(SLEN_W), .SCNT_W(SCNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .glb_en(glb_en),
    .slave_mode(slave_mode), .long_sync(long_sync), .early_pos(early_pos),
    .frame_div(frame_div), .slot_len(slot_len), .tx_slots(tx_slots),
    .rx_slots(rx_slots), .sync_in(sync_in), .fsync(fsync), .sof(sof),
    .bit_idx(bit_idx), .slot_idx(slot_idx), .cfg_err(cfg_err)
  );

  typedef struct {
    int    fs; int sf; int bi; int si; int er;
    string req;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_pos = 0;
  int m_prev = 0;
  string cur_req = "R1";

  function automatic int exp_err();
    int ms, fl;
    ms = (tx_slots > rx_slots) ? int'(tx_slots) : int'(rx_slots);
    fl = int'(frame_div) + 1;
    if (slot_len == 0) return 1;
    if (fl < int'(slot_len) * ms) return 1;
    if (long_sync && (tx_slots <= 1 || rx_slots <= 1) && fl <= int'(slot_len)) return 1;
    return 0;
  endfunction

  function automatic exp_t predict();
    exp_t e;
    int sl;
    sl = int'(slot_len);
    e.er = exp_err();
    e.req = cur_req;
    if (!glb_en || e.er != 0) begin
      e.fs = 0; e.sf = 0; e.bi = 0; e.si = 0;
    end else begin
      e.bi = m_pos % sl;
      e.si = m_pos / sl;
      e.sf = (m_pos == 0) ? 1 : 0;
      if (slave_mode)     e.fs = 0;
      else if (long_sync) e.fs = (m_pos < sl) ? 1 : 0;
      else if (early_pos) e.fs = (m_pos == int'(frame_div)) ? 1 : 0;
      else                e.fs = (m_pos == 0) ? 1 : 0;
    end
    return e;
  endfunction

  task automatic check1(string req, int got, int expv);
    n_chk++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (int'(fsync) != e.fs || int'(sof) != e.sf || int'(bit_idx) != e.bi
          || int'(slot_idx) != e.si || int'(cfg_err) != e.er) begin
        n_bad++;
        $display("FAIL %s: got fs=%0d sof=%0d bit=%0d slot=%0d err=%0d expected fs=%0d sof=%0d bit=%0d slot=%0d err=%0d",
                 e.req, fsync, sof, bit_idx, slot_idx, cfg_err, e.fs, e.sf, e.bi, e.si, e.er);
      end
    end
  end

  task automatic configure(int dv, int sl, int tx, int rx, bit lng, bit erl, bit slv);
    @(negedge clk);
    glb_en = 1'b0;
    frame_div = DIV_W'(dv); slot_len = SLEN_W'(sl);
    tx_slots = SCNT_W'(tx); rx_slots = SCNT_W'(rx);
    long_sync = lng; early_pos = erl; slave_mode = slv; sync_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    glb_en = 1'b1;
    m_pos = 0; m_prev = 0;
    @(negedge clk);
    q.push_back(predict());
  endtask

  task automatic strobe(bit s);
    bit running;
    running = glb_en && (exp_err() == 0);
    @(negedge clk);
    bclk_en = 1'b1; sync_in = s;
    @(negedge clk);
    bclk_en = 1'b0;
    if (!running) m_pos = 0;
    else begin
      if (slave_mode && s && m_prev == 0)
        m_pos = (!long_sync && early_pos) ? 0 : 1;
      else if (m_pos >= int'(frame_div)) m_pos = 0;
      else m_pos++;
      m_prev = s;
    end
    q.push_back(predict());
  endtask

  task automatic run_bits(int n);
    for (int i = 0; i < n; i++) strobe(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check1("R8 reset", int'({fsync, sof, cfg_err}), 0);
    check1("R8 reset idx", int'(bit_idx) + int'(slot_idx), 0);
    rst_n = 1'b1;

    // R3 short late, R1 R2 R11
    cur_req = "R3";
    configure(31, 8, 4, 4, 0, 0, 0);
    run_bits(70);
    // R4 short early
    cur_req = "R4";
    configure(31, 8, 4, 4, 0, 1, 0);
    run_bits(70);
    // R5 long, early ignored
    cur_req = "R5";
    configure(31, 8, 4, 2, 1, 1, 0);
    run_bits(70);
    // R1 R2 frame not a multiple of slot length
    cur_req = "R2";
    configure(36, 8, 4, 4, 0, 0, 0);
    run_bits(80);
    // R1 full divider range
    cur_req = "R1";
    configure(255, 32, 8, 8, 0, 0, 0);
    run_bits(260);

    // R6 frame too short
    cur_req = "R6";
    configure(15, 8, 4, 1, 0, 0, 0);
    check1("R6 cfg_err", int'(cfg_err), 1);
    run_bits(20);
    cur_req = "R6 zero slot";
    configure(15, 0, 1, 1, 0, 0, 0);
    run_bits(4);

    // R7 long rule, then same frame short
    cur_req = "R7";
    configure(15, 16, 1, 1, 1, 0, 0);
    check1("R7 long err", int'(cfg_err), 1);
    run_bits(10);
    configure(15, 16, 1, 1, 0, 0, 0);
    check1("R7 short ok", int'(cfg_err), 0);
    run_bits(20);

    // R10 error tracks config with enable low
    @(negedge clk);
    glb_en = 1'b0; frame_div = DIV_W'(3); slot_len = SLEN_W'(8);
    tx_slots = SCNT_W'(2); rx_slots = SCNT_W'(2); long_sync = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check1("R10 err while disabled", int'(cfg_err), 1);
    frame_div = DIV_W'(15);
    @(negedge clk);
    @(negedge clk);
    check1("R10 err cleared", int'(cfg_err), 0);

    // R8 disable mid-frame
    cur_req = "R8";
    configure(31, 8, 4, 4, 0, 0, 0);
    run_bits(13);
    @(negedge clk);
    glb_en = 1'b0;
    @(negedge clk);
    q.push_back(predict());
    run_bits(5);
    @(negedge clk);
    glb_en = 1'b1;
    m_pos = 0; m_prev = 0;
    @(negedge clk);
    q.push_back(predict());
    run_bits(40);

    // R9 slave, late placement
    cur_req = "R9";
    configure(31, 8, 4, 4, 0, 0, 1);
    run_bits(5);
    strobe(1'b1);
    strobe(1'b1);
    run_bits(20);
    strobe(1'b1);
    run_bits(40);
    // R9 slave, early placement
    configure(31, 8, 4, 4, 0, 1, 1);
    run_bits(9);
    strobe(1'b1);
    run_bits(40);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule